// File: doc/BRIEF.md
# SPI Convert-and-Readback Target for a Three-Axis Sensor

This block is the serial front end of a three-axis motion sensor. A host drives chip select, serial clock and data-in (clock idles low, data captured on the rising edge, data launched after the falling edge). The target answers on a data-out line that it drives only while it has something to send. Three kinds of transfer are decoded from the first byte.

A command with bit 7 clear is a write: one data byte follows and lands in a control register.

A command with bit 7 set is a read. If the address is one of the four even result addresses 0x00, 0x02, 0x04 or 0x06, the target starts a conversion on the matching channel: X, Y, Z or auxiliary. The host then holds the clock low until the conversion is done. The target then streams the 12-bit result left-justified in 16 bits, followed by the remaining registers in auto-increment order. Any other read address returns the stored register contents directly.

The analog sampler sits outside the block. It sees a one-cycle start pulse and a channel code. It answers with a done pulse and the sample value. Control register 0x0C holds the filter and range bits and control register 0x0D holds the power and mode bits. Both registers drive output ports toward the sampler. Writing the key 0xCA to address 0x0A pulses a calibration reload strobe. All serial pins are brought into the system clock domain through two-stage synchronisers.

Top module: `spi_accel_target`

## Requirements
- R1: After reset, register 0x0C holds 0xE1, register 0x0D holds 0x40, the data-out enable is low and the calibration strobe is low.
- R2: Data-out is not driven while chip select is high. It is also not driven during the command byte, during the data byte of a write, or while a conversion is pending.
- R3: A write sends the command byte (bit 7 = 0, address in bits 6:0) and then one data byte, MSB first. For address 0x0C the stored value is the data with bits 4:2 forced to 0. For address 0x0D the stored value is the data with bits 4:0 forced to 0. The stored value appears on the matching output port.
- R4: A read of a register address returns that register in the next byte, MSB first. Data-out changes only after a falling clock edge or when a conversion result is loaded.
- R5: Read commands 0x80, 0x82, 0x84 and 0x86 each raise a single-cycle conversion start after the eighth rising clock edge. The channel code is 0 for X, 1 for Y, 2 for Z and 3 for auxiliary.
- R6: When the conversion completes, the second and third bytes carry result bits 11 down to 0, followed by four zero bits.
- R7: Continued clocking after a byte auto-increments the address. The order runs through addresses 0x00 to 0x07 (high byte then low byte for X, Y, Z and auxiliary), then 0x0C, then 0x0D. Reading stays on 0x0D after that.
- R8: Addresses 0x08, 0x09, 0x0A and 0x0B read as 0x00. Writes to 0x08, 0x09 and 0x0B change nothing, and the next address after any of them is 0x0C.
- R9: Raising chip select ends the transfer. The next transfer starts with a new command byte, whatever the pointer was.
- R10: Writing 0xCA to address 0x0A raises the calibration strobe for exactly one clock. Any other value at that address raises nothing.
- R11: A read of an odd result address (for example 0x81) returns the stored low byte of the last result and starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from host |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host |
| spi_sdo_oe | output | 1 | Output enable for the data-out tri-state buffer |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 2 | Channel to convert (0 X, 1 Y, 2 Z, 3 aux) |
| conv_done | input | 1 | One-cycle conversion completion |
| conv_data | input | RES_W | Conversion result, valid with conv_done |
| cfg_filter | output | 8 | Contents of register 0x0C |
| cfg_power | output | 8 | Contents of register 0x0D |
| cal_reload | output | 1 | One-cycle calibration reload strobe |

## Verification
Suppose the bit counter or phase drifts. The next byte on data-out is then shifted by one or more bits, or comes from the wrong address, and this shows within the following eight clocks. Suppose the address pointer survives a chip-select rise. Then the first byte after a new command is wrong, and this shows at once. A missed result load makes the target keep data-out disabled after the conversion wait. A lost mask or a bad write decode shows on the configuration ports one clock after the last data bit. The directed scenarios therefore compare every streamed byte and the strobe counts against a model built from the address order and the register masks.

// File: rtl/spi_accel_target.sv
module spi_accel_target #(
  parameter int         RES_W       = 12,
  parameter logic [7:0] FILTER_INIT = 8'hE1,
  parameter logic [7:0] POWER_INIT  = 8'h40,
  parameter logic [7:0] CAL_KEY     = 8'hCA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_cs_n,
  input  logic             spi_sclk,
  input  logic             spi_sdi,
  output logic             spi_sdo,
  output logic             spi_sdo_oe,
  output logic             conv_start,
  output logic [1:0]       conv_chan,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic [7:0]       cfg_filter,
  output logic [7:0]       cfg_power,
  output logic             cal_reload
);

  localparam int         PAD_W      = 16 - RES_W;
  localparam logic [6:0] A_LAST_OUT = 7'h07;
  localparam logic [6:0] A_CAL      = 7'h0A;
  localparam logic [6:0] A_FILTER   = 7'h0C;
  localparam logic [6:0] A_POWER    = 7'h0D;
  localparam logic [7:0] FILTER_MSK = 8'hE3;
  localparam logic [7:0] POWER_MSK  = 8'hE0;

  typedef enum logic [2:0] {PH_CMD, PH_WDATA, PH_WAIT, PH_READ, PH_DONE} phase_t;

  logic [1:0] cs_s;
  logic [2:0] ck_s;
  logic [1:0] di_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s <= 2'b11;
      ck_s <= 3'b000;
      di_s <= 2'b00;
    end else begin
      cs_s <= {cs_s[0], spi_cs_n};
      ck_s <= {ck_s[1:0], spi_sclk};
      di_s <= {di_s[0], spi_sdi};
    end
  end

  logic cs_act, rise_e, fall_e;
  assign cs_act = !cs_s[1];
  assign rise_e = cs_act && ck_s[1] && !ck_s[2];
  assign fall_e = cs_act && !ck_s[1] && ck_s[2];

  phase_t           phase_q;
  logic [2:0]       bit_q;
  logic [6:0]       rx_q;
  logic [6:0]       addr_q;
  logic [7:0]       tx_q;
  logic             tx_live, load_pend, busy_q;
  logic [RES_W-1:0] res_q [4];

  logic [7:0] byte_in;
  logic       byte_end, is_conv;
  assign byte_in  = {rx_q, di_s[1]};
  assign byte_end = rise_e && (bit_q == 3'd7);
  assign is_conv  = byte_in[7] && (byte_in[6:3] == 4'd0) && !byte_in[0];

  function automatic logic [15:0] pad16(input logic [RES_W-1:0] w);
    return {w, {PAD_W{1'b0}}};
  endfunction

  function automatic logic [6:0] next_addr(input logic [6:0] a);
    if (a < A_LAST_OUT)   return a + 7'd1;
    else if (a < A_FILTER) return A_FILTER;
    else if (a == A_FILTER) return A_POWER;
    else return a;
  endfunction

  logic [15:0] out_word;
  logic [7:0]  rd_byte;
  always_comb begin
    out_word = pad16(res_q[addr_q[2:1]]);
    rd_byte  = 8'h00;
    if (addr_q <= A_LAST_OUT) rd_byte = addr_q[0] ? out_word[7:0] : out_word[15:8];
    else if (addr_q == A_FILTER) rd_byte = cfg_filter;
    else if (addr_q == A_POWER)  rd_byte = cfg_power;
  end

  logic [15:0] new_word;
  assign new_word = pad16(conv_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_CMD;
      bit_q      <= 3'd0;
      rx_q       <= 7'd0;
      addr_q     <= 7'd0;
      tx_q       <= 8'd0;
      tx_live    <= 1'b0;
      load_pend  <= 1'b0;
      busy_q     <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= 2'd0;
      cal_reload <= 1'b0;
      cfg_filter <= FILTER_INIT;
      cfg_power  <= POWER_INIT;
      for (int i = 0; i < 4; i++) res_q[i] <= '0;
    end else begin
      conv_start <= 1'b0;
      cal_reload <= 1'b0;
      if (conv_done && busy_q) begin
        res_q[conv_chan] <= conv_data;
        busy_q <= 1'b0;
      end
      if (!cs_act) begin
        phase_q   <= PH_CMD;
        bit_q     <= 3'd0;
        load_pend <= 1'b0;
        tx_live   <= 1'b0;
      end else begin
        if (rise_e) begin
          rx_q  <= byte_in[6:0];
          bit_q <= bit_q + 3'd1;
        end
        if (byte_end) begin
          case (phase_q)
            PH_CMD: begin
              addr_q <= byte_in[6:0];
              if (!byte_in[7]) begin
                phase_q <= PH_WDATA;
              end else if (is_conv) begin
                conv_chan  <= byte_in[2:1];
                conv_start <= 1'b1;
                busy_q     <= 1'b1;
                phase_q    <= PH_WAIT;
              end else begin
                load_pend <= 1'b1;
                phase_q   <= PH_READ;
              end
            end
            PH_WDATA: begin
              if (addr_q == A_FILTER) cfg_filter <= byte_in & FILTER_MSK;
              if (addr_q == A_POWER)  cfg_power  <= byte_in & POWER_MSK;
              if (addr_q == A_CAL)    cal_reload <= (byte_in == CAL_KEY);
              phase_q <= PH_DONE;
            end
            PH_READ: begin
              addr_q    <= next_addr(addr_q);
              load_pend <= 1'b1;
            end
            default: ;
          endcase
        end
        if (fall_e) begin
          if (load_pend) begin
            tx_q      <= rd_byte;
            tx_live   <= 1'b1;
            load_pend <= 1'b0;
          end else if (tx_live) begin
            tx_q <= {tx_q[6:0], 1'b0};
          end
        end
        if (conv_done && busy_q && phase_q == PH_WAIT) begin
          tx_q    <= new_word[15:8];
          tx_live <= 1'b1;
          phase_q <= PH_READ;
        end
      end
    end
  end

  assign spi_sdo    = tx_q[7];
  assign spi_sdo_oe = !spi_cs_n && tx_live;

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_filter[4:2] == 3'b000) && (cfg_power[4:0] == 5'b00000));

  // R3
  cfg_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_e |=> ($stable(cfg_filter) && $stable(cfg_power)));

  // R4
  sdo_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_e && !conv_done) |=> $stable(spi_sdo));

  // R5
  conv_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(rise_e));

  // R2
  quiet_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT) |-> !spi_sdo_oe);

  // R10
  cal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_reload |=> !cal_reload);

endmodule

// File: tb/spi_accel_target_bench.sv
module spi_accel_target_bench;
  localparam int HALF  = 6;
  localparam int DELAY = 50;

  logic clk = 0, rst_n = 0;
  logic spi_cs_n = 1, spi_sclk = 0, spi_sdi = 0;
  logic spi_sdo, spi_sdo_oe, conv_start, conv_done, cal_reload;
  logic [1:0] conv_chan;
  logic [11:0] conv_data;
  logic [7:0] cfg_filter, cfg_power;

  always #5 clk = ~clk;

  spi_accel_target u_spi_accel_target (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .cfg_filter(cfg_filter), .cfg_power(cfg_power),
    .cal_reload(cal_reload));

  int errors = 0, checks = 0;
  int starts = 0, cal_cnt = 0, last_ch = 0;
  logic [11:0] samp [4];
  logic [11:0] model [4];
  logic [7:0] exp_filter = 8'hE1, exp_power = 8'h40;

  int pend = 0, cnt = 0, sch = 0;
  initial begin conv_done = 0; conv_data = 0; end
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) begin
      starts <= starts + 1; last_ch <= int'(conv_chan);
      pend <= 1; cnt <= DELAY; sch <= int'(conv_chan);
    end else if (pend != 0) begin
      if (cnt == 0) begin
        conv_done <= 1'b1; conv_data <= samp[sch]; pend <= 0;
      end else cnt <= cnt - 1;
    end
    if (cal_reload) cal_cnt <= cal_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_low();
    spi_cs_n = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic xbyte(input logic [7:0] mo, output logic [7:0] mi, output logic oe);
    oe = 0;
    for (int i = 7; i >= 0; i--) begin
      spi_sdi = mo[i];
      repeat (HALF) @(negedge clk);
      mi[i] = spi_sdo;
      oe = oe | spi_sdo_oe;
      spi_sclk = 1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 0;
    end
  endtask

  function automatic logic [7:0] exp_byte(input int a);
    logic [15:0] w;
    if (a <= 7) begin
      w = {model[a / 2], 4'h0};
      return (a % 2 == 1) ? w[7:0] : w[15:8];
    end
    if (a == 12) return exp_filter;
    if (a == 13) return exp_power;
    return 8'h00;
  endfunction

  function automatic int step(input int a);
    if (a < 7) return a + 1;
    if (a < 12) return 12;
    if (a == 12) return 13;
    return a;
  endfunction

  task automatic t_write(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] mi; logic oe1, oe2;
    cs_low();
    xbyte({1'b0, a}, mi, oe1);
    xbyte(d, mi, oe2);
    cs_high();
    chk("R2 no drive during write", int'(oe1 | oe2), 0);
    if (a == 7'h0C) exp_filter = d & 8'hE3;
    if (a == 7'h0D) exp_power = d & 8'hE0;
    chk("R3 filter port", int'(cfg_filter), int'(exp_filter));
    chk("R3 power port", int'(cfg_power), int'(exp_power));
  endtask

  task automatic t_read(input int a, input int nbytes, input string req);
    logic [7:0] mi; logic oe; int ad; int s0;
    s0 = starts; ad = a;
    cs_low();
    xbyte(8'h80 | 8'(a), mi, oe);
    chk("R2 no drive during command", int'(oe), 0);
    for (int k = 0; k < nbytes; k++) begin
      xbyte(8'h00, mi, oe);
      chk(req, int'(mi), int'(exp_byte(ad)));
      chk("R4 driven", int'(oe), 1);
      ad = step(ad);
    end
    cs_high();
    chk("R11 no conversion on plain read", starts - s0, 0);
    chk("R2 released after cs", int'(spi_sdo_oe), 0);
  endtask

  task automatic t_conv(input int ch, input logic [11:0] v, input int nbytes);
    logic [7:0] mi; logic oe; int ad; int s0;
    s0 = starts; samp[ch] = v; ad = 2 * ch;
    cs_low();
    xbyte(8'h80 | 8'(2 * ch), mi, oe);
    chk("R2 no drive during command", int'(oe), 0);
    repeat (10) @(negedge clk);
    chk("R5 one start", starts - s0, 1);
    chk("R5 channel code", last_ch, ch);
    chk("R2 no drive while converting", int'(spi_sdo_oe), 0);
    repeat (DELAY + 40) @(negedge clk);
    model[ch] = v;
    for (int k = 0; k < nbytes; k++) begin
      xbyte(8'h00, mi, oe);
      if (k < 2) chk("R6 result bytes", int'(mi), int'(exp_byte(ad)));
      else       chk("R7 auto-increment", int'(mi), int'(exp_byte(ad)));
      ad = step(ad);
    end
    cs_high();
    chk("R5 still one start", starts - s0, 1);
  endtask

  logic finished = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin samp[i] = 0; model[i] = 0; end
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 filter reset", int'(cfg_filter), 8'hE1);
    chk("R1 power reset", int'(cfg_power), 8'h40);
    chk("R1 oe low", int'(spi_sdo_oe), 0);
    chk("R1 strobe low", int'(cal_reload), 0);
    t_read(12, 3, "R1 R7 control read and hold");

    t_write(7'h0C, 8'hFF);
    t_write(7'h0D, 8'h3F);
    t_read(12, 2, "R3 readback masked");
    t_write(7'h0C, 8'h61);
    t_write(7'h0D, 8'hC0);

    // R8 unused addresses
    t_write(7'h08, 8'h55);
    t_write(7'h0B, 8'h77);
    t_read(8, 2, "R8 unused reads zero then 0x0C");
    t_read(11, 2, "R8 0x0B reads zero");
    t_read(10, 1, "R8 0x0A reads zero");

    // R10 calibration key
    t_write(7'h0A, 8'h35);
    chk("R10 wrong key no strobe", cal_cnt, 0);
    t_write(7'h0A, 8'hCA);
    chk("R10 key strobe", cal_cnt, 1);

    // R5 R6 R7 conversions on each channel
    t_conv(3, 12'h5A3, 4);
    t_conv(2, 12'h0F1, 2);
    t_conv(1, 12'hFFF, 2);
    t_conv(0, 12'hABC, 12);
    t_conv(1, 12'h123, 9);

    // R11 odd result address
    t_read(1, 3, "R11 stored low byte");

    // R9 chip select resets pointer
    t_conv(0, 12'h801, 3);
    t_read(13, 1, "R9 fresh command after cs");
    t_conv(2, 12'h3C5, 1);
    t_read(12, 1, "R9 pointer not carried");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule